// File: doc/BRIEF.md
# Accumulator Datapath with Link Bit

This block holds the working accumulator of a small processor together with a one-bit link register that catches carries and takes part in rotates. On every clock edge it can apply one of nine operations to the accumulator. The operations combine it with a data operand, load it from that operand or from an 8-bit character, complement it, clear it, increment it, or rotate it one place in either direction through the link bit. The control lines come in already decoded, with at most one of them high in a cycle.

The next accumulator value comes from a row of identical per-bit slices. Each slice picks its own new bit from the operand bit, its neighbours, the shared adder's sum bit and the character bit. One adder serves both addition and increment. Two status outputs report whether the registered accumulator is zero and what its sign bit is. Instruction decode, memory access and step sequencing are done elsewhere.

Top module: `acc_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, the accumulator is 0x0000 and the link bit is 0.
- R2: `op_and` loads the accumulator with the bitwise AND of the accumulator and `dr_in`; the link bit is unchanged.
- R3: `op_add` loads the accumulator with the low 16 bits of accumulator + `dr_in`, and the link bit with the carry out of bit 15.
- R4: `op_ldr` loads the accumulator with `dr_in`; the link bit is unchanged.
- R5: `op_lchr` loads accumulator bits 7..0 with `char_in`; bits 15..8 and the link bit are unchanged.
- R6: `op_com` loads the accumulator with its bitwise complement; the link bit is unchanged.
- R7: `op_clr` loads the accumulator with 0x0000; the link bit is unchanged.
- R8: `op_inc` loads the accumulator with accumulator + 1 modulo 2^16 (0xFFFF becomes 0x0000); the link bit is unchanged and the carry is dropped.
- R9: `op_shr` rotates right through the link: new bit 15 is the old link, new bits 14..0 are old bits 15..1, and the new link is old bit 0.
- R10: `op_shl` rotates left through the link: new bit 0 is the old link, new bits 15..1 are old bits 14..0, and the new link is old bit 15.
- R11: In a cycle with no control line high, the accumulator and the link bit keep their values.
- R12: `acc_zero` is 1 exactly when the registered accumulator is 0x0000, and `acc_neg` equals bit 15 of the registered accumulator.
- R13: At most one control line is high in any cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dr_in | input | 16 | Data operand |
| char_in | input | 8 | Input character |
| op_and | input | 1 | AND operand into accumulator |
| op_add | input | 1 | Add operand, carry to link |
| op_ldr | input | 1 | Load operand |
| op_lchr | input | 1 | Load character into low byte |
| op_com | input | 1 | Complement accumulator |
| op_shr | input | 1 | Rotate right through link |
| op_shl | input | 1 | Rotate left through link |
| op_inc | input | 1 | Increment accumulator |
| op_clr | input | 1 | Clear accumulator |
| acc_out | output | 16 | Registered accumulator |
| link_out | output | 1 | Registered link bit |
| acc_zero | output | 1 | Accumulator is zero |
| acc_neg | output | 1 | Accumulator sign bit |

## Verification
Addition and both rotates write the accumulator and the link bit in the same edge, and the status outputs change in that same cycle. Rotates are therefore run with the link both set and clear and with both end bits of the accumulator varied. Additions and increments are aimed at 0xFFFF, where a carry out, a wrap to zero and the zero flag all occur together. After each operation the bench compares the accumulator, the link bit and both flags with a model updated by the same operation, so a write that goes to the wrong register, or misses one, shows up as a mismatch.

// File: rtl/acc_pkg.sv
// Package: shared widths and the decoded control bundle of the accumulator
// datapath. Assumes callers never assert more than one control field at once.
package acc_pkg;

    localparam int unsigned ACC_W  = 16;
    localparam int unsigned CHR_W  = 8;
    localparam int unsigned N_CTL  = 9;

    // One field per datapath operation; all zero means hold.
    typedef struct packed {
        logic f_and;
        logic f_add;
        logic f_ldr;
        logic f_lchr;
        logic f_com;
        logic f_shr;
        logic f_shl;
        logic f_inc;
        logic f_clr;
    } acc_ctl_t;

endpackage

// File: rtl/acc_adder.sv
// Module: acc_adder
// Shared adder for the add and increment operations. Produces W sum bits and
// the carry out of the top bit. Assumes the caller zeroes b for an increment.
module acc_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    // Full-width sum with the carry kept in one extra bit.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

endmodule

// File: rtl/acc_slice.sv
// Module: acc_slice
// Next-value logic for one accumulator bit. Picks the new bit from the
// operand, the neighbours, the adder sum bit or the character bit, according
// to the decoded control bundle. Assumes at most one control field is high.
module acc_slice
    import acc_pkg::*;
(
    input  acc_ctl_t ctl,
    input  logic     cur,      // present value of this bit
    input  logic     opnd,     // operand bit
    input  logic     sum_bit,  // adder sum bit
    input  logic     chr_bit,  // character bit, or cur for high bits
    input  logic     from_hi,  // bit that enters on a right rotate
    input  logic     from_lo,  // bit that enters on a left rotate
    output logic     nxt
);

    // Choose this bit's next value; hold when no operation is selected.
    always_comb begin
        nxt = cur;
        if (ctl.f_clr)                     nxt = 1'b0;
        else if (ctl.f_and)                nxt = cur & opnd;
        else if (ctl.f_add || ctl.f_inc)   nxt = sum_bit;
        else if (ctl.f_ldr)                nxt = opnd;
        else if (ctl.f_lchr)               nxt = chr_bit;
        else if (ctl.f_com)                nxt = ~cur;
        else if (ctl.f_shr)                nxt = from_hi;
        else if (ctl.f_shl)                nxt = from_lo;
    end

endmodule

// File: rtl/acc_status.sv
// Module: acc_status
// Status flags derived from the registered accumulator: all-zero and sign.
// Assumes its input comes straight from the accumulator flip-flops.
module acc_status #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] acc,
    output logic         is_zero,
    output logic         is_neg
);

    // Reduce the register to the two flags.
    always_comb begin
        is_zero = ~|acc;
        is_neg  = acc[W-1];
    end

endmodule

// File: rtl/acc_unit.sv
// Module: acc_unit
// Accumulator register, link flip-flop and the per-bit next-value network.
// One decoded operation is applied per clock; with none the state holds.
// Assumes the control lines are one-hot or all zero, and that reset is
// synchronous and active low.
module acc_unit
    import acc_pkg::*;
#(
    parameter int unsigned W  = ACC_W,
    parameter int unsigned CW = CHR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  dr_in,
    input  logic [CW-1:0] char_in,
    input  logic          op_and,
    input  logic          op_add,
    input  logic          op_ldr,
    input  logic          op_lchr,
    input  logic          op_com,
    input  logic          op_shr,
    input  logic          op_shl,
    input  logic          op_inc,
    input  logic          op_clr,
    output logic [W-1:0]  acc_out,
    output logic          link_out,
    output logic          acc_zero,
    output logic          acc_neg
);

    localparam int unsigned EXT_W = W + 2;

    acc_ctl_t         ctl;
    logic [W-1:0]     acc_q;
    logic             link_q;
    logic [W-1:0]     acc_d;
    logic             link_d;
    logic [W-1:0]     add_b;
    logic [W-1:0]     sum;
    logic             cout;
    logic [W-1:0]     chr_full;
    logic [EXT_W-1:0] ring;

    // Gather the decoded lines into the shared bundle.
    always_comb begin
        ctl = '{f_and: op_and, f_add: op_add, f_ldr: op_ldr, f_lchr: op_lchr,
                f_com: op_com, f_shr: op_shr, f_shl: op_shl, f_inc: op_inc,
                f_clr: op_clr};
    end

    // Operand for the adder: data on add, zero on increment.
    always_comb begin
        add_b = ctl.f_add ? dr_in : '0;
    end

    acc_adder #(.W(W)) u_add (
        .a    (acc_q),
        .b    (add_b),
        .cin  (ctl.f_inc),
        .sum  (sum),
        .cout (cout)
    );

    // Character load value: new low byte, present high bits.
    always_comb begin
        chr_full = {acc_q[W-1:CW], char_in};
    end

    // Rotate ring: the link sits at both ends of the accumulator.
    always_comb begin
        ring = {link_q, acc_q, link_q};
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        acc_slice u_slice (
            .ctl     (ctl),
            .cur     (acc_q[i]),
            .opnd    (dr_in[i]),
            .sum_bit (sum[i]),
            .chr_bit (chr_full[i]),
            .from_hi (ring[i+2]),
            .from_lo (ring[i]),
            .nxt     (acc_d[i])
        );
    end

    // Next link value: carry on add, leaving bit on a rotate, else hold.
    always_comb begin
        link_d = link_q;
        if (ctl.f_add)      link_d = cout;
        else if (ctl.f_shr) link_d = acc_q[0];
        else if (ctl.f_shl) link_d = acc_q[W-1];
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            link_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            link_q <= link_d;
        end
    end

    acc_status #(.W(W)) u_stat (
        .acc     (acc_q),
        .is_zero (acc_zero),
        .is_neg  (acc_neg)
    );

    assign acc_out  = acc_q;
    assign link_out = link_q;

    // R13
    ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_and, op_add, op_ldr, op_lchr, op_com, op_shr, op_shl, op_inc, op_clr}));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_add |=> ({link_out, acc_out} == ({1'b0, $past(acc_out)} + {1'b0, $past(dr_in)})));

    // R8
    inc_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_inc |=> (link_out == $past(link_out)) && (acc_out == $past(acc_out) + 1'b1));

    // R9
    rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_shr |=> (acc_out == {$past(link_out), $past(acc_out[W-1:1])}) && (link_out == $past(acc_out[0])));

    // R10
    rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_shl |=> (acc_out == {$past(acc_out[W-2:0]), $past(link_out)}) && (link_out == $past(acc_out[W-1])));

    // R5
    chr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_lchr |=> (acc_out[W-1:CW] == $past(acc_out[W-1:CW])) && (acc_out[CW-1:0] == $past(char_in)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_and | op_add | op_ldr | op_lchr | op_com | op_shr | op_shl | op_inc | op_clr)
        |=> $stable(acc_out) && $stable(link_out));

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_neg |-> !acc_zero);

endmodule

// File: tb/tb_acc_unit.sv
`timescale 1ns/1ps
module tb_acc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dr_in = '0;
    logic [7:0]  char_in = '0;
    logic [8:0]  ops = '0;  // {and,add,ldr,lchr,com,shr,shl,inc,clr}
    logic [15:0] acc_out;
    logic        link_out, acc_zero, acc_neg;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [15:0] m_acc = '0;
    logic        m_link = 1'b0;

    always #2 clk = ~clk;

    acc_unit dut (
        .clk(clk), .rst_n(rst_n), .dr_in(dr_in), .char_in(char_in),
        .op_and(ops[8]), .op_add(ops[7]), .op_ldr(ops[6]), .op_lchr(ops[5]),
        .op_com(ops[4]), .op_shr(ops[3]), .op_shl(ops[2]), .op_inc(ops[1]),
        .op_clr(ops[0]),
        .acc_out(acc_out), .link_out(link_out), .acc_zero(acc_zero), .acc_neg(acc_neg)
    );

    // Op codes: 0 and,1 add,2 ldr,3 lchr,4 com,5 shr,6 shl,7 inc,8 clr,9 idle
    function automatic logic [16:0] model(int op, logic [15:0] a, logic l,
                                          logic [15:0] d, logic [7:0] c);
        logic [16:0] r;
        r = {l, a};
        case (op)
            0: r = {l, a & d};
            1: r = {1'b0, a} + {1'b0, d};
            2: r = {l, d};
            3: r = {l, a[15:8], c};
            4: r = {l, ~a};
            5: r = {a[0], l, a[15:1]};
            6: r = {a[15], a[14:0], l};
            7: r = {l, a + 16'd1};
            8: r = {l, 16'h0000};
            default: r = {l, a};
        endcase
        return r;
    endfunction

    function automatic string tag(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R9";
            6: return "R10";
            7: return "R8";
            8: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic check_state(string req);
        check(req, "acc", {16'h0, acc_out}, {16'h0, m_acc});
        check(req, "link", {31'h0, link_out}, {31'h0, m_link});
        check("R12", "zero", {31'h0, acc_zero}, {31'h0, (m_acc == 16'h0)});
        check("R12", "sign", {31'h0, acc_neg}, {31'h0, m_acc[15]});
    endtask

    // Apply one op on the next edge and check the state half a cycle later.
    task automatic do_op(int op, logic [15:0] d, logic [7:0] c);
        logic [16:0] nx;
        dr_in = d;
        char_in = c;
        ops = (op < 9) ? (9'b1_0000_0000 >> op) : 9'b0;
        nx = model(op, m_acc, m_link, d, c);
        @(negedge clk);
        ops = '0;
        m_acc = nx[15:0];
        m_link = nx[16];
        check_state(tag(op));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_state("R1");

        // Carry and wrap corners (R3, R8)
        do_op(2, 16'hFFFF, 8'h00);
        do_op(1, 16'h0001, 8'h00);   // 0xFFFF + 1 -> 0, link 1
        do_op(4, 16'h0000, 8'h00);   // 0xFFFF
        do_op(7, 16'h0000, 8'h00);   // wrap, link stays 1
        do_op(1, 16'h0005, 8'h00);   // no carry, link 0
        do_op(2, 16'hFFFF, 8'h00);
        do_op(7, 16'h0000, 8'h00);   // wrap with link 0
        // Rotates through the link (R9, R10)
        do_op(2, 16'h8001, 8'h00);
        do_op(5, 16'h0000, 8'h00);
        do_op(5, 16'h0000, 8'h00);
        do_op(6, 16'h0000, 8'h00);
        do_op(6, 16'h0000, 8'h00);
        do_op(6, 16'h0000, 8'h00);
        // Character load keeps the high byte (R5)
        do_op(2, 16'hA5C3, 8'h00);
        do_op(3, 16'h1234, 8'h7E);
        // Idle hold (R11), AND (R2), clear (R7)
        do_op(9, 16'hFFFF, 8'hFF);
        do_op(9, 16'h0000, 8'h00);
        do_op(0, 16'h0FF0, 8'h00);
        do_op(8, 16'hFFFF, 8'h00);

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            logic [15:0] d;
            op = int'($urandom_range(0, 9));
            d  = 16'($urandom);
            if ($urandom_range(0, 7) == 0) d = 16'hFFFF;
            do_op(op, d, 8'($urandom));
        end

        // Synchronous reset mid-run (R1)
        do_op(2, 16'hBEEF, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0;
        m_link = 1'b0;
        check_state("R1");
        finish_run();
    end

endmodule